// File: doc/BRIEF.md
# Dual-Width Parallel Host Register Port

This block is the processor-facing side of a display controller. A host reaches it through a chip select, a register-select line, separate read and write strobes and an eight-bit data bus. A word-length select lets the same port work with a four-bit host. With register-select low, a write loads an index byte. The low four bits of that byte name one of thirteen command registers. The upper bits set the output drive mode, standby and a prescaler reset. With register-select high, a write or read reaches the command register that the index names.

Each accepted data write is also passed to the display side as a one-cycle command pulse. A write to the full-dot data register makes the busy output go low for a short time. A write to the character data register makes it go low for a long time. Data writes that arrive while busy is low are dropped, and a sticky error flag records them. All timing is counted in cycles of the oscillator clock `clk`. One internal tick is four clock cycles.

Top module: `hif_port`

## Requirements
- R1: A transfer is taken only on a falling edge of `wr_n` or `rd_n` seen while `cs_n` is low. A write strobe while `cs_n` is high changes nothing.
- R2: A write with `rsel`=0 loads the index byte. A read with `rsel`=0 returns the index byte.
- R3: A write with `rsel`=1 loads command register `idx[3:0]` when that index is 0 to 12, and a read returns it. Index values 13 to 15 take no write, raise no command pulse and read as 0x00.
- R4: With `wsel`=1, every transfer moves one nibble on `data_in[7:4]` / `data_out[7:4]`. The first nibble is the upper half of the byte and the second is the lower half. `data_out[3:0]` reads 0 in this mode.
- R5: The nibble phase returns to the upper half on reset, when `rsel` changes and when `wsel` changes. A half-sent byte is then discarded.
- R6: `disp_mode` decodes index bits 5:4. 00 gives 0 (outputs forced to the idle level), 01 gives 1 (unselected waveform) and 1x gives 2 (normal drive).
- R7: Index bit 6 is `standby`. While it is set, data writes are refused with no command pulse and data reads return 0x00. Index writes and reads still work.
- R8: Index bit 7 drives `scaler_rst` directly.
- R9: A data write accepted to register 2 holds `busy_n` low for exactly FD_TICKS×4 cycles (24 by default). One accepted to register 5 holds it low for CH_TICKS×4 cycles (200). Writes to any other register leave `busy_n` high.
- R10: A data write completed while `busy_n` is low is ignored. It sets `err_flag`, which stays set until reset.
- R11: After reset, the index byte and all command registers are zero, `busy_n` is high, `err_flag` is low and `disp_mode` is 0.
- R12: The clock edge after an accepted data write, `cmd_we` is high for one cycle with `cmd_idx` and `cmd_data` equal to the register index and the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rsel | input | 1 | 0 selects the index byte, 1 selects the indexed register |
| wsel | input | 1 | 1 selects a four-bit bus, 0 an eight-bit bus |
| wr_n | input | 1 | Write strobe, active on its falling edge |
| rd_n | input | 1 | Read strobe, active on its falling edge |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Host read data |
| data_oe | output | 1 | High while a read is driving the bus |
| busy_n | output | 1 | Low while a data write is being processed |
| disp_mode | output | 2 | Decoded output drive mode |
| standby | output | 1 | Standby bit of the index byte |
| scaler_rst | output | 1 | Prescaler reset bit of the index byte |
| err_flag | output | 1 | Sticky flag for a write refused because of busy |
| cmd_we | output | 1 | One-cycle pulse for an accepted data write |
| cmd_idx | output | 4 | Register index of the pulse |
| cmd_data | output | 8 | Data byte of the pulse |

## Verification
The assertions assume that the strobes and select lines are already synchronous to `clk`. They also assume each strobe stays low and then high for at least one clock, so that one falling edge means one transfer. The bench changes all inputs on falling clock edges, and every strobe in it lasts a full cycle in each level. The assertions also assume that standby and a data commit never fall in the same cycle. This holds because a single strobe commits either an index byte or a data byte, never both. Random traffic waits for `busy_n` before each data write, except in the directed case that writes into a busy window on purpose.

// File: rtl/hif_pkg.sv
package hif_pkg;
  typedef enum logic [1:0] {
    DRV_IDLE_LEVEL = 2'd0,
    DRV_UNSELECTED = 2'd1,
    DRV_NORMAL     = 2'd2
  } drv_mode_e;

  typedef struct packed {
    logic       scaler_rst;
    logic       standby;
    logic [1:0] drive;
    logic [3:0] reg_idx;
  } index_byte_t;
endpackage

// File: rtl/hif_strobe_edge.sv
module hif_strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= strobe_n[g];
    end
    assign fall[g] = en & prev_q & ~strobe_n[g];
  end
endmodule

// File: rtl/hif_nibble_asm.sv
module hif_nibble_asm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wsel,
  input  logic          rsel,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [DW-1:0] byte_out,
  output logic          rd_fetch,
  output logic          rd_lower
);
  localparam int HW = DW / 2;

  logic          phase_q, phase_d;
  logic          rsel_q, wsel_q;
  logic [HW-1:0] hold_q, hold_d;
  logic          mode_chg, eff_phase;

  assign mode_chg  = (rsel != rsel_q) | (wsel != wsel_q);
  assign eff_phase = mode_chg ? 1'b0 : phase_q;

  always_comb begin
    phase_d = mode_chg ? 1'b0 : phase_q;
    if ((wr_stb | rd_stb) & wsel) phase_d = ~eff_phase;
    hold_d = hold_q;
    if (wr_stb & wsel & ~eff_phase) hold_d = din[DW-1:HW];
  end

  assign commit   = wr_stb & (~wsel | eff_phase);
  assign byte_out = wsel ? {hold_q, din[DW-1:HW]} : din;
  assign rd_fetch = rd_stb & (~wsel | ~eff_phase);
  assign rd_lower = rd_stb & wsel & eff_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      rsel_q  <= 1'b0;
      wsel_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_d;
      rsel_q  <= rsel;
      wsel_q  <= wsel;
      hold_q  <= hold_d;
    end
  end

  // R5
  sel_change_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel != rsel_q) && !wr_stb && !rd_stb |=> !phase_q);
  // R4
  byte_mode_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel_q |-> !phase_q);
endmodule

// File: rtl/hif_busy_timer.sv
module hif_busy_timer #(
  parameter int MAX_CYC = 200
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [$clog2(MAX_CYC+1)-1:0] len,
  output logic                        busy_n
);
  localparam int CW = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = len;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_n = (cnt_q == '0);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && (len != '0) |=> !busy_n);
  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(start));
endmodule

// File: rtl/hif_port.sv
module hif_port #(
  parameter int DW       = 8,
  parameter int NUM_REGS = 13,
  parameter int FD_IDX   = 2,
  parameter int CH_IDX   = 5,
  parameter int FD_TICKS = 6,
  parameter int CH_TICKS = 50,
  parameter int TICK_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rsel,
  input  logic          wsel,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          busy_n,
  output logic [1:0]    disp_mode,
  output logic          standby,
  output logic          scaler_rst,
  output logic          err_flag,
  output logic          cmd_we,
  output logic [3:0]    cmd_idx,
  output logic [DW-1:0] cmd_data
);
  import hif_pkg::*;

  localparam int HW      = DW / 2;
  localparam int FD_CYC  = FD_TICKS * TICK_DIV;
  localparam int CH_CYC  = CH_TICKS * TICK_DIV;
  localparam int MAX_CYC = (FD_CYC > CH_CYC) ? FD_CYC : CH_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [1:0]    fall;
  logic          wr_stb, rd_stb;
  logic          commit, rd_fetch, rd_lower;
  logic [DW-1:0] wbyte;

  hif_strobe_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(~cs_n),
    .strobe_n({rd_n, wr_n}), .fall(fall)
  );
  assign wr_stb = fall[0];
  assign rd_stb = fall[1];

  hif_nibble_asm #(.DW(DW)) u_nib (
    .clk(clk), .rst_n(rst_n), .wsel(wsel), .rsel(rsel),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .din(data_in),
    .commit(commit), .byte_out(wbyte),
    .rd_fetch(rd_fetch), .rd_lower(rd_lower)
  );

  index_byte_t   idx_q, idx_d;
  logic [DW-1:0] regs_q [NUM_REGS];
  logic          idx_ok, data_wr, accept, refuse;
  logic          busy_start;
  logic [CW-1:0] busy_len;
  logic [DW-1:0] rd_sel, rd_byte;
  logic [DW-1:0] rd_buf_q, rd_buf_d, dout_q, dout_d;
  logic          err_q, err_d;
  logic          cmd_we_q;
  logic [3:0]    cmd_idx_q;
  logic [DW-1:0] cmd_data_q;

  assign idx_ok  = (int'(idx_q.reg_idx) < NUM_REGS);
  assign data_wr = commit & rsel & ~idx_q.standby;
  assign accept  = data_wr & busy_n & idx_ok;
  assign refuse  = data_wr & ~busy_n;

  always_comb begin
    idx_d = idx_q;
    if (commit & ~rsel) idx_d = index_byte_t'(wbyte);
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic we;
    assign we = accept & (int'(idx_q.reg_idx) == r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[r] <= '0;
      else if (we) regs_q[r] <= wbyte;
    end
  end

  always_comb begin
    busy_start = 1'b0;
    busy_len   = '0;
    if (accept && int'(idx_q.reg_idx) == FD_IDX) begin
      busy_start = 1'b1;
      busy_len   = CW'(FD_CYC);
    end else if (accept && int'(idx_q.reg_idx) == CH_IDX) begin
      busy_start = 1'b1;
      busy_len   = CW'(CH_CYC);
    end
  end

  hif_busy_timer #(.MAX_CYC(MAX_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(busy_start),
    .len(busy_len), .busy_n(busy_n)
  );

  always_comb begin
    rd_sel = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (int'(idx_q.reg_idx) == r) rd_sel = regs_q[r];
    if (!rsel)              rd_byte = DW'(idx_q);
    else if (idx_q.standby) rd_byte = '0;
    else                    rd_byte = rd_sel;
  end

  always_comb begin
    rd_buf_d = rd_buf_q;
    dout_d   = dout_q;
    if (rd_fetch) begin
      rd_buf_d = rd_byte;
      dout_d   = wsel ? {rd_byte[DW-1:HW], {HW{1'b0}}} : rd_byte;
    end else if (rd_lower) begin
      dout_d   = {rd_buf_q[HW-1:0], {HW{1'b0}}};
    end
    err_d = err_q | refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      rd_buf_q   <= '0;
      dout_q     <= '0;
      err_q      <= 1'b0;
      cmd_we_q   <= 1'b0;
      cmd_idx_q  <= '0;
      cmd_data_q <= '0;
    end else begin
      idx_q    <= idx_d;
      rd_buf_q <= rd_buf_d;
      dout_q   <= dout_d;
      err_q    <= err_d;
      cmd_we_q <= accept;
      if (accept) begin
        cmd_idx_q  <= idx_q.reg_idx;
        cmd_data_q <= wbyte;
      end
    end
  end

  assign data_out   = dout_q;
  assign data_oe    = ~cs_n & ~rd_n;
  assign disp_mode  = idx_q.drive[1] ? DRV_NORMAL
                    : (idx_q.drive[0] ? DRV_UNSELECTED : DRV_IDLE_LEVEL);
  assign standby    = idx_q.standby;
  assign scaler_rst = idx_q.scaler_rst;
  assign err_flag   = err_q;
  assign cmd_we     = cmd_we_q;
  assign cmd_idx    = cmd_idx_q;
  assign cmd_data   = cmd_data_q;

  // R7
  no_cmd_in_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |-> !standby);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R3
  cmd_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |-> (int'(cmd_idx) < NUM_REGS));
  // R12
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> !cmd_we);
  // R1
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !cmd_we);
endmodule

// File: tb/hif_port_bench.sv
module hif_port_bench;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, rsel, wsel, wr_n, rd_n;
  logic [7:0] data_in, data_out, cmd_data;
  logic       data_oe, busy_n, standby, scaler_rst, err_flag, cmd_we;
  logic [1:0] disp_mode;
  logic [3:0] cmd_idx;

  hif_port u_hif_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rsel(rsel), .wsel(wsel),
    .wr_n(wr_n), .rd_n(rd_n), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .busy_n(busy_n), .disp_mode(disp_mode),
    .standby(standby), .scaler_rst(scaler_rst), .err_flag(err_flag),
    .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_data(cmd_data)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int busy_run = 0, last_run = 0, cmd_count = 0;
  logic [3:0] last_cmd_idx;
  logic [7:0] last_cmd_data;
  logic [7:0] model [13];
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_run = 0;
    end else begin
      if (!busy_n) busy_run = busy_run + 1;
      else if (busy_run != 0) begin last_run = busy_run; busy_run = 0; end
      if (cmd_we) begin
        cmd_count = cmd_count + 1;
        last_cmd_idx = cmd_idx;
        last_cmd_data = cmd_data;
      end
    end
  end

  function automatic int exp_busy(int idx);
    if (idx == 2) return 24;
    if (idx == 5) return 200;
    return 0;
  endfunction

  function automatic logic [1:0] exp_mode(logic [7:0] ib);
    return ib[5] ? 2'd2 : {1'b0, ib[4]};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(bit is_wr, bit rs, logic [7:0] d, bit cs_on = 1);
    @(negedge clk);
    cs_n = ~cs_on; rsel = rs; data_in = d;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic write_byte(bit rs, logic [7:0] d);
    if (wsel) begin
      strobe(1, rs, {d[7:4], 4'h0});
      strobe(1, rs, {d[3:0], 4'h0});
    end else strobe(1, rs, d);
  endtask

  task automatic read_byte(bit rs, output logic [7:0] v);
    if (wsel) begin
      strobe(0, rs, 8'h00);
      v[7:4] = data_out[7:4];
      strobe(0, rs, 8'h00);
      v[3:0] = data_out[7:4];
    end else begin
      strobe(0, rs, 8'h00);
      v = data_out;
    end
  endtask

  task automatic wait_idle();
    while (!busy_n) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int c0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cs_n = 1'b1; rsel = 1'b0; wsel = 1'b0;
    wr_n = 1'b1; rd_n = 1'b1; data_in = '0;
    for (int i = 0; i < 13; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 busy_n", busy_n, 1);
    check("R11 err_flag", err_flag, 0);
    check("R11 disp_mode", disp_mode, 0);
    read_byte(0, v); check("R11 index", v, 0);
    read_byte(1, v); check("R11 reg0", v, 0);

    // R2 / R6 / R3 / R12 basic 8-bit
    write_byte(0, 8'h23);
    check("R6 normal", disp_mode, exp_mode(8'h23));
    read_byte(0, v); check("R2 index readback", v, 8'h23);
    c0 = cmd_count;
    write_byte(1, 8'hA5); model[3] = 8'hA5;
    @(negedge clk);
    check("R12 count", cmd_count, c0 + 1);
    check("R12 idx", last_cmd_idx, 3);
    check("R12 data", last_cmd_data, 8'hA5);
    read_byte(1, v); check("R3 reg3", v, 8'hA5);
    check("R9 no busy reg3", last_run, 0);

    // R6 other modes
    write_byte(0, 8'h03); check("R6 idle", disp_mode, 0);
    write_byte(0, 8'h13); check("R6 unsel", disp_mode, 1);
    write_byte(0, 8'h33); check("R6 normal11", disp_mode, 2);

    // R1 write with cs high ignored
    c0 = cmd_count;
    strobe(1, 1, 8'h11, 0);
    @(negedge clk);
    check("R1 no cmd", cmd_count, c0);
    read_byte(1, v); check("R1 reg3 kept", v, 8'hA5);

    // R9 busy lengths
    write_byte(0, 8'h22);
    write_byte(1, 8'h5A); model[2] = 8'h5A;
    wait_idle(); check("R9 full-dot busy", last_run, exp_busy(2));
    write_byte(0, 8'h25);
    write_byte(1, 8'h3C); model[5] = 8'h3C;
    wait_idle(); check("R9 char busy", last_run, exp_busy(5));

    // R10 write during busy
    write_byte(1, 8'h77); model[5] = 8'h77;
    check("R10 no err yet", err_flag, 0);
    write_byte(1, 8'h88);
    check("R10 err set", err_flag, 1);
    wait_idle();
    read_byte(1, v); check("R10 reg5 kept", v, 8'h77);
    check("R10 sticky", err_flag, 1);

    // R4 four-bit mode
    wsel = 1'b1; @(negedge clk);
    write_byte(0, 8'h24);
    write_byte(1, 8'hC3); model[4] = 8'hC3;
    read_byte(1, v); check("R4 nibble read", v, 8'hC3);
    wsel = 1'b0; @(negedge clk);
    read_byte(1, v); check("R4 byte read", v, 8'hC3);
    wsel = 1'b1; @(negedge clk);
    strobe(0, 1, 8'h00);
    check("R4 low bits zero", data_out[3:0], 0);

    // R5 phase reset on rsel change
    wsel = 1'b0; @(negedge clk); wsel = 1'b1; @(negedge clk);
    strobe(1, 1, 8'hE0);
    write_byte(0, 8'h26);
    read_byte(0, v); check("R5 rsel change index", v, 8'h26);
    read_byte(1, v); check("R5 reg6 untouched", v, model[6]);
    // R5 phase reset on wsel change
    strobe(1, 1, 8'hB0);
    wsel = 1'b0; @(negedge clk);
    write_byte(1, 8'h9C); model[6] = 8'h9C;
    read_byte(1, v); check("R5 wsel change reg6", v, 8'h9C);

    // R7 standby
    write_byte(0, 8'h63);
    check("R7 standby", standby, 1);
    c0 = cmd_count;
    write_byte(1, 8'h44);
    @(negedge clk);
    check("R7 no cmd", cmd_count, c0);
    read_byte(1, v); check("R7 read zero", v, 0);
    read_byte(0, v); check("R7 index readable", v, 8'h63);
    write_byte(0, 8'h23);
    read_byte(1, v); check("R7 reg3 kept", v, model[3]);

    // R8 scaler reset
    write_byte(0, 8'hA3);
    check("R8 scaler set", scaler_rst, 1);
    check("R8 standby clear", standby, 0);
    write_byte(0, 8'h23);
    check("R8 scaler clear", scaler_rst, 0);

    // R3 out-of-range index
    c0 = cmd_count;
    write_byte(0, 8'h2D);
    write_byte(1, 8'h55);
    @(negedge clk);
    check("R3 no cmd idx13", cmd_count, c0);
    read_byte(1, v); check("R3 idx13 reads 0", v, 0);

    // random traffic
    for (int it = 0; it < 60; it++) begin
      int ri;
      logic [7:0] rd, ib;
      ri = $urandom_range(0, 12);
      rd = 8'($urandom);
      ib = {2'b00, 2'($urandom_range(0, 3)), 4'(ri)};
      wsel = 1'($urandom); @(negedge clk);
      write_byte(0, ib);
      check("R6 random mode", disp_mode, exp_mode(ib));
      wait_idle();
      write_byte(1, rd); model[ri] = rd;
      if (ri == 2 || ri == 5) begin
        wait_idle(); check("R9 random busy", last_run, exp_busy(ri));
      end
      wsel = 1'($urandom); @(negedge clk);
      read_byte(1, v); check("R3 random readback", v, model[ri]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule